// File: doc/BRIEF.md
# Keyed-Write Watchdog Interval Timer

This block is an 8-bit interval timer driven through a single 16-bit write port. The upper byte of every write acts as a key. One key value sends the lower byte to the control/status register. A second key value sends it to the counter. Any other key is discarded, so a stray store of the wrong width or pattern cannot reprogram the timer or restart its count.

When the enable bit in control is set, a prescaler divides the input clock, and each prescaler period advances the counter by one. The divide ratio comes from a 3-bit select field. Select 0 gives a period of 2 clocks. Any other select value s gives a period of 32 shifted left by s clocks, so the longest period is 4096 clocks.

When the counter steps from 0xFF it wraps to 0x00. On that step the block emits a one-cycle interrupt pulse. The pulse comes with a 4-bit priority level and a 7-bit vector, both captured from configuration inputs at the moment of overflow. Software reads the current control and counter values directly from the output ports.

Top module: `wdt_timer`

## Requirements
- R1: A write with upper byte 0xA5 loads wr_data[7:0] into control; ctrl_q shows it from the next cycle.
- R2: A write with upper byte 0x5A loads wr_data[7:0] into the counter; count_q shows it from the next cycle.
- R3: A write with any other upper byte leaves control, the counter and the prescaler phase unchanged.
- R4: Control bits [2:0] set the prescale period: 2 clocks for value 0, and (32 << s) clocks for value s from 1 to 7.
- R5: Control bit 5 enables counting. While it is 0, count_q holds its value unless the counter is written.
- R6: A step from 0xFF wraps the counter to 0x00. irq is high for exactly one cycle, the cycle in which count_q first reads 0x00.
- R7: During the irq pulse, irq_level equals prio_cfg[7:4] and irq_vector equals vec_cfg[6:0], as sampled at the overflow step.
- R8: Any control write restarts the prescaler. The first counter step after a control write that enables counting comes exactly one full period after that write's clock edge.
- R9: After reset, ctrl_q, count_q and irq are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the keyed port |
| wr_data | input | 16 | Key in [15:8], payload in [7:0] |
| prio_cfg | input | 8 | Priority register; the upper nibble is the interrupt level |
| vec_cfg | input | 8 | Vector register; the low 7 bits are the interrupt vector |
| ctrl_q | output | 8 | Current control/status value |
| count_q | output | 8 | Current counter value |
| irq | output | 1 | One-cycle overflow interrupt pulse |
| irq_level | output | 4 | Level carried with the interrupt |
| irq_vector | output | 7 | Vector carried with the interrupt |

## Verification
The bench runs every prescale select from a preloaded count of 0xFE. It checks the cycle of the first step, the cycle of the overflow, and the pulse count. An off-by-one period or a wrong shift for select 0 therefore moves the overflow to the wrong cycle, and a stretched or repeated pulse shows up as an extra count.

A control rewrite partway through a period is checked for restarting the period; a design that kept the old accumulator would step too early. A wrong-key write made partway through a period must leave both registers and the step timing unchanged.

Holding with enable clear catches a design that gates on the wrong bit. Changing the priority and vector inputs between runs catches a design that swaps or mis-slices those fields.

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int SEL0_DIV = 2,
  parameter int BASE_DIV = 32,
  parameter int EN_BIT   = 5,
  parameter logic [7:0] KEY_CTRL = 8'hA5,
  parameter logic [7:0] KEY_CNT  = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic [7:0]  prio_cfg,
  input  logic [7:0]  vec_cfg,
  output logic [7:0]  ctrl_q,
  output logic [7:0]  count_q,
  output logic        irq,
  output logic [3:0]  irq_level,
  output logic [6:0]  irq_vector
);
  localparam int PRE_W = $clog2(BASE_DIV << 7) + 1;

  logic [PRE_W-1:0] acc_q;
  logic [PRE_W-1:0] acc_inc;
  logic [PRE_W-1:0] period;
  logic             ctrl_wr, cnt_wr, running, tick, wrap;

  assign ctrl_wr = wr_en && (wr_data[15:8] == KEY_CTRL);
  assign cnt_wr  = wr_en && (wr_data[15:8] == KEY_CNT);
  assign running = ctrl_q[EN_BIT];
  assign acc_inc = acc_q + 1'b1;
  assign period  = (ctrl_q[2:0] == 3'd0) ? PRE_W'(SEL0_DIV)
                                         : PRE_W'(BASE_DIV) << ctrl_q[2:0];
  assign tick    = running && !ctrl_wr && (acc_inc == period);
  assign wrap    = tick && !cnt_wr && (count_q == 8'hFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      acc_q  <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= wr_data[7:0];
      acc_q  <= '0;
    end else if (running) begin
      acc_q  <= tick ? '0 : acc_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_wr) count_q <= wr_data[7:0];
    else if (tick)   count_q <= count_q + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      irq_level  <= '0;
      irq_vector <= '0;
    end else begin
      irq <= wrap;
      if (wrap) begin
        irq_level  <= prio_cfg[7:4];
        irq_vector <= vec_cfg[6:0];
      end
    end
  end
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [7:0]  prio_cfg,
  input logic [7:0]  vec_cfg,
  input logic [7:0]  ctrl_q,
  input logic [7:0]  count_q,
  input logic        irq,
  input logic [3:0]  irq_level,
  input logic [6:0]  irq_vector
);
  // R1
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:8] == 8'hA5) |=> ctrl_q == $past(wr_data[7:0]));

  // R2
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:8] == 8'h5A) |=> count_q == $past(wr_data[7:0]));

  // R3
  ctrl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[15:8] == 8'hA5) |=> $stable(ctrl_q));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[5] && !wr_en) |=> $stable(count_q));

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6
  pulse_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> count_q == 8'h00);

  // R7
  level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (irq_level == $past(prio_cfg[7:4]) && irq_vector == $past(vec_cfg[6:0])));
endmodule

bind wdt_timer wdt_timer_chk chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .prio_cfg(prio_cfg), .vec_cfg(vec_cfg), .ctrl_q(ctrl_q), .count_q(count_q),
  .irq(irq), .irq_level(irq_level), .irq_vector(irq_vector)
);

// File: tb/wdt_timer_test.sv
module wdt_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  prio_cfg = '0;
  logic [7:0]  vec_cfg = '0;
  logic [7:0]  ctrl_q, count_q;
  logic        irq;
  logic [3:0]  irq_level;
  logic [6:0]  irq_vector;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  wdt_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .prio_cfg(prio_cfg), .vec_cfg(vec_cfg), .ctrl_q(ctrl_q), .count_q(count_q),
    .irq(irq), .irq_level(irq_level), .irq_vector(irq_vector)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d expected<=200000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    checks = checks + 1;
    if (actual !== expected) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  function automatic int period_of(input int s);
    return (s == 0) ? 2 : (32 << s);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 ctrl", ctrl_q, 0);
    check("R9 count", count_q, 0);
    check("R9 irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R2 and R5: load both registers with the enable bit clear, then hold
    wr(16'hA505);
    check("R1 ctrl readback", ctrl_q, 8'h05);
    wr(16'h5A77);
    check("R2 count readback", count_q, 8'h77);
    repeat (300) @(negedge clk);
    check("R5 hold while disabled", count_q, 8'h77);

    // R4, R6, R7: sweep every prescale select
    for (int s = 0; s < 8; s++) begin
      int p, first, pulses;
      p = period_of(s);
      prio_cfg = 8'h30 + 8'(s * 16) + 8'h0F;
      vec_cfg  = 8'h80 | 8'(s * 9 + 3);
      wr(16'hA500);
      wr(16'h5AFE);
      wr(16'hA520 | 16'(s));
      first = 0;
      pulses = 0;
      for (int n = 1; n <= 2 * p + 1; n++) begin
        @(negedge clk);
        if (n == p - 1) check($sformatf("R4 sel%0d before step", s), count_q, 8'hFE);
        if (n == p)     check($sformatf("R4 sel%0d first step", s), count_q, 8'hFF);
        if (irq) begin
          pulses++;
          if (first == 0) begin
            first = n;
            check($sformatf("R6 sel%0d wrap value", s), count_q, 8'h00);
            check($sformatf("R7 sel%0d level", s), irq_level, int'(prio_cfg[7:4]));
            check($sformatf("R7 sel%0d vector", s), irq_vector, int'(vec_cfg[6:0]));
          end
        end
      end
      check($sformatf("R6 sel%0d overflow cycle", s), first, 2 * p);
      check($sformatf("R6 sel%0d pulse count", s), pulses, 1);
    end

    // R8: rewrite control partway through a period
    wr(16'hA500);
    wr(16'h5A10);
    wr(16'hA521);
    repeat (40) @(negedge clk);
    wr(16'hA521);
    for (int n = 1; n <= 64; n++) begin
      @(negedge clk);
      if (n == 63) check("R8 no early step", count_q, 8'h10);
      if (n == 64) check("R8 step one period after rewrite", count_q, 8'h11);
    end

    // R3: wrong-key writes partway through a period change nothing
    wr(16'hA500);
    wr(16'h5A40);
    wr(16'hA521);
    for (int n = 1; n <= 64; n++) begin
      @(negedge clk);
      if (n == 10) begin wr_en = 1'b1; wr_data = 16'h1234; end
      if (n == 11) begin wr_data = 16'h00FF; end
      if (n == 12) begin wr_en = 1'b0; wr_data = '0; end
      if (n == 13) begin
        check("R3 ctrl unchanged", ctrl_q, 8'h21);
        check("R3 count unchanged", count_q, 8'h40);
      end
      if (n == 63) check("R3 phase kept", count_q, 8'h40);
      if (n == 64) check("R3 step on time", count_q, 8'h41);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule